// File: doc/BRIEF.md
# Storage command request sequencer

This block is the user-facing command front end of a block-storage host engine. A requester presents a 3-bit command code, a 48-bit start sector and a 48-bit sector count, then raises a request. The block answers on a busy line: busy rises when the command is taken and falls when the command has finished. Inside, the block tracks the phase of the engine. After reset it waits for initialization to finish. It then moves between idle and busy, and it ends in a permanent inactive phase after a shutdown, an initialization failure or a failed device command.

The block enforces the ordering and parameter rules. Write and read need a completed identify first. The range must be non-empty and must fit inside the capacity that identify reported. In 4 KB sector mode, both address and length must be aligned to 8 sectors. Write and read transfers are cut into device commands of 256 sectors (128 KB) each, with a shorter last one. These go one per cycle to a downstream issue port. A window of outstanding commands is tracked against single-cycle done pulses. Every other valid code goes down as one item with a zero count. After an identify completes, the block records the capacity and sector mode that the engine returned.

Top module: `stor_cmd_front`

## Requirements
- R1: After reset, busy is 1, the error flag is 0, the capacity is 0 and the sector mode is 0. Busy stays 1 until init_done is seen, and then falls in the next cycle.
- R2: If init_fail is seen during initialization, the block sets err, drops busy and from then on ignores every request until reset.
- R3: A request is taken only while busy is 0. Busy is 1 in the cycle after the request was sampled. Busy returns to 0 only after the command has finished.
- R4: Command codes are 000 identify, 001 shutdown, 010 write, 011 read, 100 custom admin and 110 flush. The codes 101 and 111 raise param_err and issue nothing.
- R5: A write (010) or read (011) that arrives before any identify has completed raises param_err and issues nothing.
- R6: A write or read raises param_err and issues nothing if its length is 0 or if address plus length is greater than the recorded capacity. A range that ends exactly at the capacity is legal.
- R7: When the sector mode is 1 (4 KB), a write or read whose address[2:0] or length[2:0] is non-zero raises param_err and issues nothing.
- R8: A legal write or read issues chunks in ascending order. Each chunk has a count of min(remaining, 256) sectors and starts where the previous one ended, the first one at the request address. dn_op carries the request's command code.
- R9: At most MAX_OUT (4) chunks are outstanding. Busy falls only after the done pulse of every issued chunk has arrived.
- R10: Identify, shutdown, custom admin and flush each issue exactly one item, with address 0 and count 0. param_err is cleared when the next request is taken.
- R11: After a shutdown completes, busy is 0, err stays 0 and no later request is taken until reset.
- R12: A done pulse that carries dn_fail stops further issue. Once the outstanding chunks have drained, the block sets err, drops busy and becomes inactive.
- R13: The capacity and sector mode change only when an identify completes without failure. They then take the id_cap and id_4k values that were present with that identify's done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| init_done | input | 1 | Engine initialization finished |
| init_fail | input | 1 | Engine initialization failed |
| req | input | 1 | Command request |
| cmd | input | 3 | Command code |
| addr | input | 48 | Start sector (512-byte units) |
| len | input | 48 | Sector count (512-byte units) |
| busy | output | 1 | Command or initialization in progress |
| err | output | 1 | Fatal error, block inactive |
| param_err | output | 1 | Last request was rejected |
| cap | output | 48 | Recorded capacity in sectors |
| sect4k | output | 1 | Recorded sector mode, 1 = 4 KB |
| id_cap | input | 48 | Capacity returned by identify |
| id_4k | input | 1 | Sector mode returned by identify |
| dn_valid | output | 1 | Issue one device command this cycle |
| dn_op | output | 3 | Command code of the issued item |
| dn_addr | output | 48 | Chunk start sector |
| dn_cnt | output | 16 | Chunk sector count |
| dn_done | input | 1 | One issued item completed |
| dn_fail | input | 1 | The completing item failed, valid with dn_done |

## Verification
A wrong phase shows at once on busy. A missed transition leaves busy high until the watchdog fires. A missed inactive phase lets a later request raise busy within one cycle. A wrong remaining-count or next-address register shows on the first chunk that follows it, as a dn_addr or dn_cnt that differs from the running sum kept by the bench. A miscounted outstanding window shows as a fifth issue before a done arrives, or as busy falling while done pulses are still pending. A faulty check stage shows in the cycle busy falls, as a param_err that disagrees with the rules, or as chunks issued for a rejected request.

// File: rtl/stor_cmd_pkg.sv
package stor_cmd_pkg;

  localparam int SECT_W     = 48;
  localparam int CNT_W      = 16;
  localparam int ALIGN_BITS = 3;

  localparam logic [2:0] OP_IDENT  = 3'b000;
  localparam logic [2:0] OP_SHUT   = 3'b001;
  localparam logic [2:0] OP_WRITE  = 3'b010;
  localparam logic [2:0] OP_READ   = 3'b011;
  localparam logic [2:0] OP_CUSTOM = 3'b100;
  localparam logic [2:0] OP_FLUSH  = 3'b110;

  typedef enum logic [2:0] {
    PH_INIT,
    PH_IDLE,
    PH_CHECK,
    PH_RUN,
    PH_OFF
  } phase_t;

  function automatic logic op_moves_data(input logic [2:0] op);
    return (op == OP_WRITE) || (op == OP_READ);
  endfunction

  function automatic logic op_known(input logic [2:0] op);
    logic k;
    case (op)
      OP_IDENT, OP_SHUT, OP_WRITE, OP_READ, OP_CUSTOM, OP_FLUSH: k = 1'b1;
      default: k = 1'b0;
    endcase
    return k;
  endfunction

  // non-empty and ending at or below the capacity
  function automatic logic span_ok(input logic [SECT_W-1:0] a,
                                   input logic [SECT_W-1:0] n,
                                   input logic [SECT_W-1:0] c);
    logic [SECT_W:0] last_excl;
    last_excl = {1'b0, a} + {1'b0, n};
    return (n != '0) && (last_excl <= {1'b0, c});
  endfunction

  function automatic logic align_ok(input logic [SECT_W-1:0] a,
                                    input logic [SECT_W-1:0] n,
                                    input logic m4k);
    return !m4k || ((a[ALIGN_BITS-1:0] == '0) && (n[ALIGN_BITS-1:0] == '0));
  endfunction

  function automatic logic [CNT_W-1:0] next_chunk(input logic [SECT_W-1:0] remain,
                                                  input logic [SECT_W-1:0] limit);
    logic [SECT_W-1:0] pick;
    pick = (remain > limit) ? limit : remain;
    return pick[CNT_W-1:0];
  endfunction

endpackage

// File: rtl/stor_param_chk.sv
module stor_param_chk
  import stor_cmd_pkg::*;
(
  input  logic [2:0]        op,
  input  logic [SECT_W-1:0] addr,
  input  logic [SECT_W-1:0] len,
  input  logic [SECT_W-1:0] cap,
  input  logic              m4k,
  input  logic              id_seen,
  output logic              ok,
  output logic              data_op
);

  logic known, range_good, aligned;

  always_comb begin
    known      = op_known(op);
    data_op    = op_moves_data(op);
    range_good = span_ok(addr, len, cap);
    aligned    = align_ok(addr, len, m4k);
    ok         = known && (!data_op || (id_seen && range_good && aligned));
  end

endmodule

// File: rtl/stor_chunker.sv
module stor_chunker
  import stor_cmd_pkg::*;
#(
  parameter int CHUNK_SECT = 256,
  parameter int MAX_OUT    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              single,
  input  logic [SECT_W-1:0] base,
  input  logic [SECT_W-1:0] total,
  input  logic              dn_done,
  input  logic              dn_fail,
  output logic              dn_valid,
  output logic [SECT_W-1:0] dn_addr,
  output logic [CNT_W-1:0]  dn_cnt,
  output logic              fin,
  output logic              failed,
  output logic              active
);

  localparam int OUT_W = $clog2(MAX_OUT + 1);
  localparam logic [SECT_W-1:0] CHUNK_L = SECT_W'(CHUNK_SECT);
  localparam logic [OUT_W-1:0]  OUT_MAX = OUT_W'(MAX_OUT);

  logic              pend_single;
  logic [SECT_W-1:0] nxt_addr;
  logic [SECT_W-1:0] remain;
  logic [OUT_W-1:0]  outst;
  logic              fail_seen;
  logic              pend;
  logic              room;

  assign pend     = (pend_single || (remain != '0)) && !fail_seen;
  assign room     = outst < OUT_MAX;
  assign dn_valid = active && pend && room;
  assign dn_cnt   = pend_single ? '0 : next_chunk(remain, CHUNK_L);
  assign dn_addr  = pend_single ? '0 : nxt_addr;
  assign fin      = active && !pend && (outst == '0);
  assign failed   = fail_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active      <= 1'b0;
      pend_single <= 1'b0;
      nxt_addr    <= '0;
      remain      <= '0;
      outst       <= '0;
      fail_seen   <= 1'b0;
    end else if (start) begin
      active      <= 1'b1;
      pend_single <= single;
      nxt_addr    <= base;
      remain      <= single ? '0 : total;
      outst       <= '0;
      fail_seen   <= 1'b0;
    end else begin
      if (dn_valid) begin
        pend_single <= 1'b0;
        nxt_addr    <= nxt_addr + SECT_W'(dn_cnt);
        remain      <= remain - SECT_W'(dn_cnt);
      end
      case ({dn_valid, dn_done})
        2'b10:   outst <= outst + OUT_W'(1);
        2'b01:   outst <= outst - OUT_W'(1);
        default: outst <= outst;
      endcase
      if (dn_done && dn_fail) fail_seen <= 1'b1;
      if (fin) active <= 1'b0;
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    outst <= OUT_MAX);

  // R9
  done_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_done |-> (outst != '0));

  // R8
  chunk_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !pend_single) |-> ((dn_cnt != '0) && (SECT_W'(dn_cnt) <= CHUNK_L)));

  // R3
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active);

endmodule

// File: rtl/stor_cmd_front.sv
module stor_cmd_front
  import stor_cmd_pkg::*;
#(
  parameter int CHUNK_SECT = 256,
  parameter int MAX_OUT    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_done,
  input  logic              init_fail,
  input  logic              req,
  input  logic [2:0]        cmd,
  input  logic [SECT_W-1:0] addr,
  input  logic [SECT_W-1:0] len,
  output logic              busy,
  output logic              err,
  output logic              param_err,
  output logic [SECT_W-1:0] cap,
  output logic              sect4k,
  input  logic [SECT_W-1:0] id_cap,
  input  logic              id_4k,
  output logic              dn_valid,
  output logic [2:0]        dn_op,
  output logic [SECT_W-1:0] dn_addr,
  output logic [CNT_W-1:0]  dn_cnt,
  input  logic              dn_done,
  input  logic              dn_fail
);

  phase_t            phase;
  logic [2:0]        cur_cmd;
  logic [SECT_W-1:0] cur_addr, cur_len;
  logic [SECT_W-1:0] cap_r, shadow_cap;
  logic              m4k_r, shadow_m4k;
  logic              id_seen, err_r, perr_r;

  logic chk_ok, chk_data;
  logic run_start, run_fin, run_failed, run_active;
  logic accept_ev;

  assign accept_ev = (phase == PH_IDLE) && req;
  assign run_start = (phase == PH_CHECK) && chk_ok;

  stor_param_chk u_chk (
    .op      (cur_cmd),
    .addr    (cur_addr),
    .len     (cur_len),
    .cap     (cap_r),
    .m4k     (m4k_r),
    .id_seen (id_seen),
    .ok      (chk_ok),
    .data_op (chk_data)
  );

  stor_chunker #(
    .CHUNK_SECT (CHUNK_SECT),
    .MAX_OUT    (MAX_OUT)
  ) u_run (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (run_start),
    .single   (!chk_data),
    .base     (cur_addr),
    .total    (cur_len),
    .dn_done  (dn_done),
    .dn_fail  (dn_fail),
    .dn_valid (dn_valid),
    .dn_addr  (dn_addr),
    .dn_cnt   (dn_cnt),
    .fin      (run_fin),
    .failed   (run_failed),
    .active   (run_active)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= PH_INIT;
      cur_cmd    <= '0;
      cur_addr   <= '0;
      cur_len    <= '0;
      cap_r      <= '0;
      m4k_r      <= 1'b0;
      shadow_cap <= '0;
      shadow_m4k <= 1'b0;
      id_seen    <= 1'b0;
      err_r      <= 1'b0;
      perr_r     <= 1'b0;
    end else begin
      case (phase)
        PH_INIT: begin
          if (init_fail) begin
            err_r <= 1'b1;
            phase <= PH_OFF;
          end else if (init_done) begin
            phase <= PH_IDLE;
          end
        end
        PH_IDLE: begin
          if (accept_ev) begin
            cur_cmd  <= cmd;
            cur_addr <= addr;
            cur_len  <= len;
            perr_r   <= 1'b0;
            phase    <= PH_CHECK;
          end
        end
        PH_CHECK: begin
          if (chk_ok) begin
            phase <= PH_RUN;
          end else begin
            perr_r <= 1'b1;
            phase  <= PH_IDLE;
          end
        end
        PH_RUN: begin
          if (dn_done && (cur_cmd == OP_IDENT)) begin
            shadow_cap <= id_cap;
            shadow_m4k <= id_4k;
          end
          if (run_fin) begin
            if (run_failed) begin
              err_r <= 1'b1;
              phase <= PH_OFF;
            end else begin
              if (cur_cmd == OP_IDENT) begin
                cap_r   <= shadow_cap;
                m4k_r   <= shadow_m4k;
                id_seen <= 1'b1;
              end
              phase <= (cur_cmd == OP_SHUT) ? PH_OFF : PH_IDLE;
            end
          end
        end
        PH_OFF:  phase <= PH_OFF;
        default: phase <= PH_OFF;
      endcase
    end
  end

  assign busy      = (phase == PH_INIT) || (phase == PH_CHECK) || (phase == PH_RUN);
  assign err       = err_r;
  assign param_err = perr_r;
  assign cap       = cap_r;
  assign sect4k    = m4k_r;
  assign dn_op     = cur_cmd;

  // R11
  off_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_OFF) |=> (phase == PH_OFF) && !busy);

  // R3
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> busy);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !dn_valid);

  // R13
  cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(run_fin && (cur_cmd == OP_IDENT)) |=> ($stable(cap_r) && $stable(m4k_r)));

  // R5
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perr_r |-> !run_active);

endmodule

// File: tb/stor_cmd_front_tb.sv
`timescale 1ns/1ps
module stor_cmd_front_tb;

  localparam int LAT  = 6;
  localparam int MAXO = 4;
  localparam logic [47:0] CAP_A = 48'h100000;
  localparam logic [47:0] CAP_B = 48'h8000;

  typedef struct packed {
    logic [2:0]  op;
    logic [47:0] a;
    logic [47:0] n;
    logic        perr;
    logic [7:0]  nchunk;
  } vec_t;

  // sector mode 512 B, capacity CAP_A
  localparam vec_t VEC [10] = '{
    '{3'b010, 48'd0,       48'd256,  1'b0, 8'd1},
    '{3'b011, 48'd100,     48'd1000, 1'b0, 8'd4},
    '{3'b010, 48'd5,       48'd2000, 1'b0, 8'd8},
    '{3'b010, 48'd0,       48'd0,    1'b1, 8'd0},
    '{3'b011, 48'hFFFF6,   48'd11,   1'b1, 8'd0},
    '{3'b011, 48'hFFFF6,   48'd10,   1'b0, 8'd1},
    '{3'b101, 48'd0,       48'd8,    1'b1, 8'd0},
    '{3'b111, 48'd0,       48'd8,    1'b1, 8'd0},
    '{3'b110, 48'd0,       48'd0,    1'b0, 8'd1},
    '{3'b100, 48'd0,       48'd0,    1'b0, 8'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        init_done, init_fail, req;
  logic [2:0]  cmd;
  logic [47:0] addr, len, id_cap;
  logic        id_4k;
  logic        busy, err, param_err, sect4k;
  logic [47:0] cap;
  logic        dn_valid;
  logic [2:0]  dn_op;
  logic [47:0] dn_addr;
  logic [15:0] dn_cnt;
  logic        dn_done, dn_fail;
  logic        fail_arm;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  // monitor state, written only by the monitor process
  int          log_n = 0;
  int          bout = 0;
  int          peak = 0;
  int          ovf = 0;
  logic [LAT-1:0] sr;
  logic [2:0]  log_op   [64];
  logic [47:0] log_addr [64];
  logic [15:0] log_cnt  [64];

  always #2 clk = ~clk;

  stor_cmd_front u_dut (
    .clk(clk), .rst_n(rst_n), .init_done(init_done), .init_fail(init_fail),
    .req(req), .cmd(cmd), .addr(addr), .len(len),
    .busy(busy), .err(err), .param_err(param_err), .cap(cap), .sect4k(sect4k),
    .id_cap(id_cap), .id_4k(id_4k),
    .dn_valid(dn_valid), .dn_op(dn_op), .dn_addr(dn_addr), .dn_cnt(dn_cnt),
    .dn_done(dn_done), .dn_fail(dn_fail)
  );

  // downstream stub and issue monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      sr = '0;
      bout = 0;
      dn_done <= 1'b0;
      dn_fail <= 1'b0;
    end else begin
      if (dn_done) bout = bout - 1;
      if (bout > peak) peak = bout;
      if (dn_valid) begin
        if (bout >= MAXO) ovf = ovf + 1;
        log_op[log_n % 64]   = dn_op;
        log_addr[log_n % 64] = dn_addr;
        log_cnt[log_n % 64]  = dn_cnt;
        log_n = log_n + 1;
        bout = bout + 1;
      end
      sr = {sr[LAT-2:0], dn_valid};
      dn_done <= sr[LAT-1];
      dn_fail <= sr[LAT-1] & fail_arm;
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc == 150000) begin
      failures = failures + 1;
      $display("FAIL R3 watchdog expired act=%0d exp=%0d", cyc, 0);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = 1'b0; init_done = 1'b0; init_fail = 1'b0;
    fail_arm = 1'b0; cmd = '0; addr = '0; len = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic do_init();
    init_done = 1'b1;
    @(negedge clk);
    init_done = 1'b0;
  endtask

  // issue one request; returns chunks issued, busy-after-request and mismatch count
  task automatic run_cmd(input logic [2:0] op, input logic [47:0] a, input logic [47:0] n,
                         output int nis, output logic rose, output int bad);
    int first;
    int t;
    logic [47:0] ea, er, ec;
    first = log_n;
    cmd = op; addr = a; len = n; req = 1'b1;
    @(negedge clk);
    rose = busy;
    req = 1'b0;
    t = 0;
    while (busy && t < 5000) begin
      @(negedge clk);
      t = t + 1;
    end
    repeat (2) @(negedge clk);
    nis = log_n - first;
    bad = 0;
    ea = a; er = n;
    for (int i = first; i < log_n; i++) begin
      if (log_op[i % 64] != op) bad = bad + 1;
      if (op == 3'b010 || op == 3'b011) begin
        ec = (er > 48'd256) ? 48'd256 : er;
        if (log_addr[i % 64] != ea || log_cnt[i % 64] != ec[15:0]) bad = bad + 1;
        ea = ea + ec;
        er = er - ec;
      end else if (log_addr[i % 64] != 48'd0 || log_cnt[i % 64] != 16'd0) begin
        bad = bad + 1;
      end
    end
  endtask

  int   nis, bad;
  logic rose;

  initial begin
    do_reset();
    // R1 reset state
    chk(busy == 1'b1, "R1 busy after reset", busy, 1);
    chk(err == 1'b0, "R1 err after reset", err, 0);
    chk(cap == 48'd0, "R1 cap after reset", cap, 0);
    chk(sect4k == 1'b0, "R1 sector mode after reset", sect4k, 0);
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R1 busy held during init", busy, 1);
    do_init();
    chk(busy == 1'b0, "R1 busy after init_done", busy, 0);

    // R5 write before identify
    run_cmd(3'b010, 48'd0, 48'd8, nis, rose, bad);
    chk(rose == 1'b1, "R3 busy rose", rose, 1);
    chk(param_err == 1'b1, "R5 param_err before identify", param_err, 1);
    chk(nis == 0, "R5 nothing issued", nis, 0);

    // identify, 512 B mode
    id_cap = CAP_A; id_4k = 1'b0;
    run_cmd(3'b000, 48'd0, 48'd0, nis, rose, bad);
    chk(param_err == 1'b0, "R10 param_err cleared", param_err, 0);
    chk(nis == 1 && bad == 0, "R10 identify single item", nis, 1);
    chk(cap == CAP_A, "R13 cap after identify", cap, CAP_A);
    chk(sect4k == 1'b0, "R13 mode after identify", sect4k, 0);

    // vector table: R4 R6 R8 R10
    for (int i = 0; i < 10; i++) begin
      id_cap = 48'h123;
      id_4k = 1'b1;
      run_cmd(VEC[i].op, VEC[i].a, VEC[i].n, nis, rose, bad);
      chk(rose == 1'b1, $sformatf("R3 busy rose vec %0d", i), rose, 1);
      chk(param_err == VEC[i].perr, $sformatf("R4 R6 param flag vec %0d", i), param_err, VEC[i].perr);
      chk(nis == int'(VEC[i].nchunk), $sformatf("R8 R10 item count vec %0d", i), nis, VEC[i].nchunk);
      chk(bad == 0, $sformatf("R8 chunk address/count/op vec %0d", i), bad, 0);
    end
    chk(peak == MAXO, "R9 outstanding window reached", peak, MAXO);
    chk(ovf == 0, "R9 no issue beyond window", ovf, 0);
    chk(cap == CAP_A && sect4k == 1'b0, "R13 cap unchanged by other commands", cap, CAP_A);

    // identify in 4 KB mode, then alignment rules
    id_cap = CAP_B; id_4k = 1'b1;
    run_cmd(3'b000, 48'd0, 48'd0, nis, rose, bad);
    chk(cap == CAP_B && sect4k == 1'b1, "R13 second identify", cap, CAP_B);
    run_cmd(3'b010, 48'd3, 48'd8, nis, rose, bad);
    chk(param_err == 1'b1 && nis == 0, "R7 misaligned address", param_err, 1);
    run_cmd(3'b011, 48'd8, 48'd12, nis, rose, bad);
    chk(param_err == 1'b1 && nis == 0, "R7 misaligned length", param_err, 1);
    run_cmd(3'b010, 48'd8, 48'd16, nis, rose, bad);
    chk(param_err == 1'b0 && nis == 1 && bad == 0, "R7 aligned accepted", nis, 1);

    // R11 shutdown
    run_cmd(3'b001, 48'd0, 48'd0, nis, rose, bad);
    chk(nis == 1 && busy == 1'b0 && err == 1'b0, "R11 shutdown completes", {busy, err}, 0);
    run_cmd(3'b010, 48'd8, 48'd16, nis, rose, bad);
    chk(rose == 1'b0 && nis == 0, "R11 request ignored after shutdown", rose, 0);

    // R2 init failure
    do_reset();
    chk(cap == 48'd0 && sect4k == 1'b0, "R1 cap cleared by reset", cap, 0);
    init_fail = 1'b1;
    @(negedge clk);
    init_fail = 1'b0;
    chk(err == 1'b1 && busy == 1'b0, "R2 init failure", {err, busy}, 2);
    run_cmd(3'b000, 48'd0, 48'd0, nis, rose, bad);
    chk(rose == 1'b0 && nis == 0, "R2 request ignored after init failure", rose, 0);

    // R12 device failure mid-transfer
    do_reset();
    do_init();
    id_cap = CAP_A; id_4k = 1'b0;
    run_cmd(3'b000, 48'd0, 48'd0, nis, rose, bad);
    fail_arm = 1'b1;
    run_cmd(3'b011, 48'd0, 48'd2000, nis, rose, bad);
    fail_arm = 1'b0;
    chk(err == 1'b1 && busy == 1'b0, "R12 failure makes inactive", {err, busy}, 2);
    chk(nis < 8 && bad == 0, "R12 issue stops after failure", nis, 4);
    run_cmd(3'b011, 48'd0, 48'd8, nis, rose, bad);
    chk(rose == 1'b0 && nis == 0, "R12 request ignored after failure", rose, 0);

    summary();
    $finish;
  end

endmodule